// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block owns the status/control word of a floating-point unit. Software writes the word to pick a rounding mode, to enable or disable the flushing of denormal operands, and to choose which IEEE exception classes may trap. The block decodes those fields into two control lines for the arithmetic core: a truncation select and a flush-to-zero select.

When the core finishes an operation it pulses a completion strobe and presents five raw exception indicators. The block clears the per-operation flags and loads them from the indicators. It merges any new indicators into a sticky cause field. If the merged cause meets an enabled class, it raises a one-cycle trap carrying a fixed vector. Compare operations are handled apart from the others. An ordered compare only writes the condition bit, and the status word is left alone. An unordered compare updates the status exactly like any other operation.

Top module: `fpu_status_ctrl`

## Requirements
- R1: A write (`wr_en_i`) stores `wr_data_i` bits 18:0 into `csr_o`; bits 31:19 always read zero. A write takes priority over a completion strobe in the same cycle, and that completion is dropped: no status change, no condition-bit change, no trap.
- R2: `round_zero_o` is 1 exactly when `csr_o[1:0]` holds code 2'b01 (truncate toward zero). The codes 00, 10 and 11 give 0 (nearest-even).
- R3: `flush_zero_o` equals the denormal-flush bit `csr_o[18]`.
- R4: On each status-updating completion, the flag field `csr_o[6:2]` is replaced by `exc_i`. The bit order is: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. The same order applies to `exc_i[4:0]`.
- R5: The cause field is `csr_o[16:12]` (same order as the flags). It accumulates `exc_i` by OR and is never cleared by a completion. `csr_o[17]` is an extra cause bit that only a write changes, and it never traps.
- R6: A completion with `cmp_i=1` and `unord_i=0` loads `cmp_true_i` into `t_bit_o` and leaves `csr_o` unchanged. A completion with `cmp_i=1` and `unord_i=1` updates the status as in R4/R5 and leaves `t_bit_o` unchanged.
- R7: `trap_o` is high for exactly the one cycle after a status-updating completion in which `exc_i` is nonzero and the updated cause bits 16:12 AND the enable bits 11:7 (same order) is nonzero. It is low at all other times.
- R8: `trap_vec_o` reads 12'h120 while `trap_o` is high, and 0 otherwise.
- R9: After reset, `csr_o`, `t_bit_o` and `trap_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Status word write data |
| op_done_i | input | 1 | Operation completion strobe from the core |
| cmp_i | input | 1 | Completing operation is a compare |
| unord_i | input | 1 | Compare result is unordered |
| cmp_true_i | input | 1 | Compare outcome for the condition bit |
| exc_i | input | 5 | Raw exceptions {invalid, div0, overflow, underflow, inexact} |
| csr_o | output | 32 | Status/control word |
| t_bit_o | output | 1 | Condition bit from ordered compares |
| round_zero_o | output | 1 | Core rounding: 1 truncate, 0 nearest-even |
| flush_zero_o | output | 1 | Core denormal flush enable |
| trap_o | output | 1 | FP exception trap pulse |
| trap_vec_o | output | 12 | Trap vector code |

## Verification
The whole status word is visible on `csr_o`, so a wrong flag or cause bit shows up in the cycle after the completion that produced it. A cause bit that was wrongly dropped or kept shows up later, as a missing or extra `trap_o` on a following completion whose own exceptions alone would not decide the trap. The bench drives directed corner cases and then random mixes of writes, compares and ordinary completions. After every edge it compares every output against a behavioural model. Because the comparison runs each cycle, a divergence in timing (a trap one cycle late, or a dropped write-versus-completion priority) is reported in the cycle where it occurs.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned RM_W    = 2;
  localparam int unsigned EXC_W   = 5;
  localparam int unsigned CAUSE_W = EXC_W + 1;
  localparam int unsigned CSR_W   = 32;
  localparam int unsigned USED_W  = RM_W + 2 * EXC_W + CAUSE_W + 1;
  localparam int unsigned RSVD_W  = CSR_W - USED_W;
  localparam logic [CSR_W-1:0] WR_MASK = CSR_W'((64'd1 << USED_W) - 64'd1);
  localparam logic [RM_W-1:0]  RM_TRUNC = 2'b01;
  localparam int unsigned VEC_W   = 12;
  localparam logic [VEC_W-1:0] FP_TRAP_VEC = 12'h120;

  typedef struct packed {
    logic [RSVD_W-1:0]  rsvd;
    logic               dn;
    logic [CAUSE_W-1:0] cause;
    logic [EXC_W-1:0]   en;
    logic [EXC_W-1:0]   flag;
    logic [RM_W-1:0]    rm;
  } fpsr_t;
endpackage

// File: rtl/fpsr_exc_eval.sv
module fpsr_exc_eval
  import fpsr_pkg::*;
(
  input  fpsr_t            cur_i,
  input  logic [EXC_W-1:0] exc_i,
  output fpsr_t            nxt_o,
  output logic             trap_req_o
);
  logic [CAUSE_W-1:0] exc_ext;
  logic [CAUSE_W-1:0] cause_nxt;

  assign exc_ext = {1'b0, exc_i};

  always_comb begin
    nxt_o      = cur_i;
    nxt_o.flag = exc_i;
    cause_nxt  = cur_i.cause;
    if (|exc_i) cause_nxt = cur_i.cause | exc_ext;
    nxt_o.cause = cause_nxt;
  end

  // trap only when this operation raised something
  assign trap_req_o = (|exc_i) && (|(cause_nxt[EXC_W-1:0] & cur_i.en));
endmodule

// File: rtl/fpsr_round_dec.sv
module fpsr_round_dec
  import fpsr_pkg::*;
(
  input  logic [RM_W-1:0] rm_i,
  input  logic            dn_i,
  output logic            round_zero_o,
  output logic            flush_zero_o
);
  assign round_zero_o = (rm_i == RM_TRUNC);
  assign flush_zero_o = dn_i;
endmodule

// File: rtl/fpsr_reg.sv
module fpsr_reg
  import fpsr_pkg::*;
#(
  parameter logic [CSR_W-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CSR_W-1:0] wr_data_i,
  input  logic             upd_i,
  input  logic             cmp_load_i,
  input  logic             cmp_true_i,
  input  logic [EXC_W-1:0] exc_i,
  input  fpsr_t            nxt_i,
  output fpsr_t            csr_o,
  output logic             t_o
);
  fpsr_t csr_q;
  logic  t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= fpsr_t'(RESET_VAL & WR_MASK);
      t_q   <= 1'b0;
    end else if (wr_en_i) begin
      csr_q <= fpsr_t'(wr_data_i & WR_MASK);
    end else begin
      if (upd_i)      csr_q <= nxt_i;
      if (cmp_load_i) t_q   <= cmp_true_i;
    end
  end

  assign csr_o = csr_q;
  assign t_o   = t_q;

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_q.rsvd == '0);

  p_flag_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> csr_q.flag == $past(exc_i));

  p_cause_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> (csr_q.cause & $past(csr_q.cause)) == $past(csr_q.cause));

  p_cmp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_load_i && !wr_en_i) |=> csr_q == $past(csr_q));
endmodule

// File: rtl/fpsr_trap.sv
module fpsr_trap
  import fpsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] vec_o
);
  logic trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= fire_i;
  end

  assign trap_o = trap_q;
  assign vec_o  = trap_q ? FP_TRAP_VEC : '0;

  p_trap_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> $past(fire_i));
endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpsr_pkg::*;
#(
  parameter logic [CSR_W-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CSR_W-1:0] wr_data_i,
  input  logic             op_done_i,
  input  logic             cmp_i,
  input  logic             unord_i,
  input  logic             cmp_true_i,
  input  logic [EXC_W-1:0] exc_i,
  output logic [CSR_W-1:0] csr_o,
  output logic             t_bit_o,
  output logic             round_zero_o,
  output logic             flush_zero_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  fpsr_t csr;
  fpsr_t nxt;
  logic  trap_req;
  logic  done_ok;
  logic  upd;
  logic  cmp_load;

  // a same-cycle write discards the completion
  assign done_ok  = op_done_i && !wr_en_i;
  assign cmp_load = done_ok && cmp_i && !unord_i;
  assign upd      = done_ok && !(cmp_i && !unord_i);

  fpsr_exc_eval u_eval (
    .cur_i      (csr),
    .exc_i      (exc_i),
    .nxt_o      (nxt),
    .trap_req_o (trap_req)
  );

  fpsr_reg #(.RESET_VAL(RESET_VAL)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .upd_i      (upd),
    .cmp_load_i (cmp_load),
    .cmp_true_i (cmp_true_i),
    .exc_i      (exc_i),
    .nxt_i      (nxt),
    .csr_o      (csr),
    .t_o        (t_bit_o)
  );

  fpsr_trap u_trap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (upd && trap_req),
    .trap_o (trap_o),
    .vec_o  (trap_vec_o)
  );

  fpsr_round_dec u_dec (
    .rm_i         (csr.rm),
    .dn_i         (csr.dn),
    .round_zero_o (round_zero_o),
    .flush_zero_o (flush_zero_o)
  );

  assign csr_o = csr;
endmodule

// File: tb/test_fpu_status_ctrl.sv
module test_fpu_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        done = 1'b0, cmp = 1'b0, unord = 1'b0, ctrue = 1'b0;
  logic [4:0]  exc = '0;
  logic [31:0] csr;
  logic        tbit, rz, fz, trap;
  logic [11:0] vec;

  int checks = 0, fails = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_csr = '0;
  logic        m_t = 1'b0, m_trap = 1'b0;

  always #4 clk = ~clk;

  fpu_status_ctrl i_fpu_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .op_done_i(done), .cmp_i(cmp), .unord_i(unord), .cmp_true_i(ctrue),
    .exc_i(exc), .csr_o(csr), .t_bit_o(tbit), .round_zero_o(rz),
    .flush_zero_o(fz), .trap_o(trap), .trap_vec_o(vec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 csr word", csr, m_csr);
    chk("R1 reserved zero", {19'd0, csr[31:19]}, 32'd0);
    chk("R2 round select", {31'd0, rz}, {31'd0, m_csr[1:0] == 2'b01});
    chk("R3 flush select", {31'd0, fz}, {31'd0, m_csr[18]});
    chk("R4 flags", {27'd0, csr[6:2]}, {27'd0, m_csr[6:2]});
    chk("R5 cause", {26'd0, csr[17:12]}, {26'd0, m_csr[17:12]});
    chk("R6 t bit", {31'd0, tbit}, {31'd0, m_t});
    chk("R7 trap", {31'd0, trap}, {31'd0, m_trap});
    chk("R8 vector", {20'd0, vec}, m_trap ? 32'h120 : 32'h0);
  endtask

  task automatic cyc(input logic w, input logic [31:0] wd, input logic d,
                     input logic c, input logic u, input logic ct, input logic [4:0] e);
    logic [5:0] cz;
    wr_en = w; wr_data = wd; done = d; cmp = c; unord = u; ctrue = ct; exc = e;
    @(posedge clk);
    m_trap = 1'b0;
    if (w) begin
      m_csr = wd & 32'h0007_FFFF;
    end else if (d) begin
      if (c && !u) begin
        m_t = ct;
      end else begin
        m_csr[6:2] = e;
        cz = m_csr[17:12] | {1'b0, e};
        m_csr[17:12] = cz;
        m_trap = (e != 0) && ((cz[4:0] & m_csr[11:7]) != 0);
      end
    end
    #2;
    wr_en = 1'b0; done = 1'b0; cmp = 1'b0; unord = 1'b0; exc = '0;
    compare_all();
  endtask

  task automatic op(input logic [4:0] e);
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, e);
  endtask

  task automatic wr(input logic [31:0] d);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    compare_all();                 // R9 reset state
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 compare_all();

    wr(32'hFFFF_FFFF);             // R1 mask, R3 flush on, R2 code 11
    wr(32'h0000_0001);             // R2 code 01 -> truncate
    wr(32'h0000_0002);             // R2 code 10
    wr(32'h0000_0000);
    op(5'b00001);                  // R4 inexact, R5 cause, no trap
    op(5'b00000);                  // R4 flags cleared, R5 cause kept
    op(5'b10010);                  // R4 several flags
    wr(32'h0000_0400);             // enable div0 (bit 10)
    op(5'b01000);                  // R7 trap
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0); // R7 pulse ends
    cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 5'b10000); // R6 ordered compare
    cyc(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0, 5'b10000); // R6 unordered: sticky div0 traps (R7)
    op(5'b01000); op(5'b01000);    // R7 back-to-back traps
    op(5'b00000);                  // R7 no exceptions, no trap
    cyc(1'b1, 32'h0002_0000, 1'b1, 1'b0, 1'b0, 1'b0, 5'b11111); // R1 write wins
    wr(32'h0002_0F80);             // R5 extra cause bit with all enables
    op(5'b00000);                  // no trap from extra bit
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 0, $urandom, r[4] | r[5], r[6] & r[7], r[8], r[9],
          r[12] ? r[20:16] : 5'd0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule